// File: doc/BRIEF.md
# DMA Linked-List Descriptor Loader

This block sits beside a DMA channel engine. When an element transfer finishes and the channel's count field is zero, it decides whether the channel finishes or chains to another descriptor. If the channel's link pointer is non-zero, it fetches a four-word little-endian descriptor over a read-only master port. It then hands each new word back to the channel as a one-cycle update strobe on a shared data bus. If the pointer is zero, it writes back the channel configuration word with the enable bit cleared.

Completion is reported with a one-cycle `done` pulse. The terminal-count flag pulses alongside `done` when bit 31 of the control word, as it stands after the step, is set. A bus error during the fetch ends the step early, disables the channel and pulses an error flag.

Top module: `dma_chain_loader`

## Requirements
- R1: A chain step starts only on a clock edge where `elem_done` is 1 and the count field `ctrl_in[11:0]` is zero. With a non-zero count, or with `elem_done` low, no read is issued, no update strobe fires and `done` stays low.
- R2: If `link_in[31:2]` is zero when a step starts, no read is issued. In the next cycle `upd_cfg` pulses with `upd_data` equal to `cfg_in` with bit 0 cleared, and `done` pulses in that same cycle.
- R3: If `link_in[31:2]` is non-zero, four reads are issued at B+0, B+4, B+12 and B+8, in that order, where B is `link_in` with bits 1:0 forced to zero.
- R4: Only one read is outstanding at a time. `rd_req` and `rd_addr` hold steady until `rd_valid` or `rd_err` is seen. Each read completes one cycle after its response when the response is immediate.
- R5: The cycle after each valid response, exactly one update strobe pulses, with `upd_data` equal to the word read. The strobes go in the order source (B+0), destination (B+4), control (B+12) and link (B+8). The link update is always the last.
- R6: `done` pulses together with the final write-back. `tc_flag` pulses with it exactly when bit 31 of the newly loaded control word is 1 (after a reload), or bit 31 of `ctrl_in` is 1 (after a disable).
- R7: `busy` is high from the cycle after the trigger through the `done` cycle, and low afterwards. A trigger that arrives while `busy` is high is ignored.
- R8: A `rd_err` response ends the fetch. No further reads are issued. In the next cycle `upd_cfg` pulses with `cfg_in` bit 0 cleared, and `err_flag` and `done` pulse, with `tc_flag` low. Words already loaded stay loaded.
- R9: After reset, all strobes, flags, `busy` and `rd_req` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| elem_done | input | 1 | An element transfer has just finished |
| ctrl_in | input | 32 | Current channel control word; count field in bits 11:0, interrupt bit 31 |
| link_in | input | AW | Current channel link pointer |
| cfg_in | input | 32 | Current channel configuration word; enable in bit 0 |
| rd_req | output | 1 | Read request, held until a response |
| rd_addr | output | AW | Read address |
| rd_valid | input | 1 | Read data valid |
| rd_err | input | 1 | Read error response |
| rd_data | input | 32 | Read data |
| upd_src | output | 1 | Load source address from `upd_data` |
| upd_dst | output | 1 | Load destination address from `upd_data` |
| upd_ctrl | output | 1 | Load control word from `upd_data` |
| upd_link | output | 1 | Load link pointer from `upd_data` |
| upd_cfg | output | 1 | Load configuration word from `upd_data` |
| upd_data | output | 32 | Write-back data |
| busy | output | 1 | Chain step in progress |
| done | output | 1 | Chain step finished (one cycle) |
| tc_flag | output | 1 | Terminal-count interrupt pulse |
| err_flag | output | 1 | Fetch aborted by a bus error |

## Verification
A wrong fetch step counter shows up on `rd_addr` at the very next request: the bench sees a misordered or missing offset, or a write-back strobe of the wrong kind, one cycle after the response. A stale captured control word or base address shows up only at the end of the step, as a `tc_flag` that disagrees with bit 31 of the word just written, or as wrong reads on the next chain. A stuck fetch state leaves `busy` high with `done` never pulsing, so the bench catches it as a timeout on the step.

// File: rtl/dma_chain_loader.sv
module dma_chain_loader #(
  parameter int AW    = 32,
  parameter int CNT_W = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          elem_done,
  input  logic [31:0]   ctrl_in,
  input  logic [AW-1:0] link_in,
  input  logic [31:0]   cfg_in,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_valid,
  input  logic          rd_err,
  input  logic [31:0]   rd_data,
  output logic          upd_src,
  output logic          upd_dst,
  output logic          upd_ctrl,
  output logic          upd_link,
  output logic          upd_cfg,
  output logic [31:0]   upd_data,
  output logic          busy,
  output logic          done,
  output logic          tc_flag,
  output logic          err_flag
);

  logic          fetching;
  logic [1:0]    step;
  logic [AW-1:0] base;
  logic [31:0]   new_ctrl;
  logic [AW-1:0] off;
  logic          trig;
  logic          link_zero;
  logic          unused_bits;

  assign unused_bits = ^{link_in[1:0], ctrl_in[30:CNT_W]};
  assign busy      = fetching | done;
  assign trig      = elem_done && (ctrl_in[CNT_W-1:0] == '0) && !busy;
  assign link_zero = (link_in[AW-1:2] == '0);
  assign rd_req    = fetching;
  assign rd_addr   = base + off;

  always_comb begin
    case (step)
      2'd0:    off = AW'(0);
      2'd1:    off = AW'(4);
      2'd2:    off = AW'(12);
      default: off = AW'(8);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fetching <= 1'b0;
      step     <= 2'd0;
      base     <= '0;
      new_ctrl <= '0;
      upd_src  <= 1'b0;
      upd_dst  <= 1'b0;
      upd_ctrl <= 1'b0;
      upd_link <= 1'b0;
      upd_cfg  <= 1'b0;
      upd_data <= '0;
      done     <= 1'b0;
      tc_flag  <= 1'b0;
      err_flag <= 1'b0;
    end else begin
      upd_src  <= 1'b0;
      upd_dst  <= 1'b0;
      upd_ctrl <= 1'b0;
      upd_link <= 1'b0;
      upd_cfg  <= 1'b0;
      done     <= 1'b0;
      tc_flag  <= 1'b0;
      err_flag <= 1'b0;
      if (trig) begin
        if (link_zero) begin
          upd_cfg  <= 1'b1;
          upd_data <= cfg_in & ~32'd1;
          done     <= 1'b1;
          tc_flag  <= ctrl_in[31];
        end else begin
          fetching <= 1'b1;
          step     <= 2'd0;
          base     <= {link_in[AW-1:2], 2'b00};
        end
      end else if (fetching && rd_err) begin
        fetching <= 1'b0;
        upd_cfg  <= 1'b1;
        upd_data <= cfg_in & ~32'd1;
        err_flag <= 1'b1;
        done     <= 1'b1;
      end else if (fetching && rd_valid) begin
        upd_data <= rd_data;
        step     <= step + 2'd1;
        case (step)
          2'd0: upd_src <= 1'b1;
          2'd1: upd_dst <= 1'b1;
          2'd2: begin
            upd_ctrl <= 1'b1;
            new_ctrl <= rd_data;
          end
          default: begin
            upd_link <= 1'b1;
            done     <= 1'b1;
            tc_flag  <= new_ctrl[31];
            fetching <= 1'b0;
          end
        endcase
      end
    end
  end

  // R4
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !rd_valid && !rd_err |=> rd_req && $stable(rd_addr));

  // R5
  one_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({upd_src, upd_dst, upd_ctrl, upd_link, upd_cfg}));

  // R6
  tc_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tc_flag |-> done);

  // R8
  err_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |-> upd_cfg && done && !tc_flag && !rd_req);

  // R1
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(elem_done));

endmodule

// File: tb/sim_dma_chain_loader.sv
module sim_dma_chain_loader;
  localparam int CLK = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        elem_done = 1'b0;
  logic [31:0] ctrl_in = '0, link_in = '0, cfg_in = '0;
  logic        rd_req;
  logic [31:0] rd_addr;
  logic        rd_valid = 1'b0, rd_err = 1'b0;
  logic [31:0] rd_data = '0;
  logic        upd_src, upd_dst, upd_ctrl, upd_link, upd_cfg;
  logic [31:0] upd_data;
  logic        busy, done, tc_flag, err_flag;

  dma_chain_loader u0 (
    .clk(clk), .rst_n(rst_n), .elem_done(elem_done), .ctrl_in(ctrl_in),
    .link_in(link_in), .cfg_in(cfg_in), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_valid(rd_valid), .rd_err(rd_err), .rd_data(rd_data),
    .upd_src(upd_src), .upd_dst(upd_dst), .upd_ctrl(upd_ctrl),
    .upd_link(upd_link), .upd_cfg(upd_cfg), .upd_data(upd_data),
    .busy(busy), .done(done), .tc_flag(tc_flag), .err_flag(err_flag));

  always #(CLK/2) clk = ~clk;

  int vectors = 0, miscompares = 0;
  logic [31:0] mem [0:63];
  int lat = 0;
  logic [31:0] err_addr = 32'hFFFF_FFFF;

  int cyc = 0;
  int rn = 0, wn = 0;
  logic [31:0] rlog [0:15];
  int wkind [0:15];
  logic [31:0] wdata [0:15];
  int done_cnt = 0, done_cyc = 0, tc_cnt = 0, err_cnt = 0, busy_cnt = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // memory responder, drives at negedge
  initial begin
    int wc;
    wc = 0;
    forever begin
      @(negedge clk);
      rd_valid = 1'b0;
      rd_err = 1'b0;
      if (rd_req) begin
        if (wc >= lat) begin
          wc = 0;
          if (rn < 16) rlog[rn] = rd_addr;
          rn++;
          if (rd_addr == err_addr) rd_err = 1'b1;
          else begin
            rd_valid = 1'b1;
            rd_data = mem[rd_addr[7:2]];
          end
        end else wc++;
      end else wc = 0;
    end
  end

  // output monitor, just after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      cyc++;
      if (busy) busy_cnt++;
      if (done) begin done_cnt++; done_cyc = cyc; end
      if (tc_flag) tc_cnt++;
      if (err_flag) err_cnt++;
      if (upd_src || upd_dst || upd_ctrl || upd_link || upd_cfg) begin
        if (wn < 16) begin
          wkind[wn] = upd_src ? 0 : upd_dst ? 1 : upd_ctrl ? 2 : upd_link ? 3 : 4;
          wdata[wn] = upd_data;
        end
        wn++;
      end
    end
  end

  initial begin
    #(CLK*150000);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  task automatic clear_logs();
    rn = 0; wn = 0; done_cnt = 0; tc_cnt = 0; err_cnt = 0; busy_cnt = 0; done_cyc = 0;
  endtask

  task automatic fire(input logic [31:0] ctl, input logic [31:0] lnk,
                      input logic [31:0] cfg, output int tcyc);
    @(negedge clk);
    ctrl_in = ctl; link_in = lnk; cfg_in = cfg; elem_done = 1'b1;
    tcyc = cyc + 1;
    @(negedge clk);
    elem_done = 1'b0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 100; i++) begin
      if (done_cnt > 0) break;
      @(negedge clk);
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R9 rd_req", {31'd0, rd_req}, 32'd0);
    check("R9 busy", {31'd0, busy}, 32'd0);
    check("R9 flags", {28'd0, done, tc_flag, err_flag, upd_cfg}, 32'd0);
    check("R9 strobes", {28'd0, upd_src, upd_dst, upd_ctrl, upd_link}, 32'd0);
  endtask

  task automatic t_nonzero_count();
    int tc;
    clear_logs();
    fire(32'h8000_0005, 32'h40, 32'h1, tc);
    @(negedge clk);
    ctrl_in = 32'h8000_0000; link_in = 32'h40;   // count zero but no elem_done
    repeat (10) @(negedge clk);
    check("R1 no reads", rn, 0);
    check("R1 no updates", wn, 0);
    check("R1 no done", done_cnt, 0);
    check("R1 no busy", busy_cnt, 0);
  endtask

  task automatic t_zero_link(input logic [31:0] lnk, input logic [31:0] ctl, input int exp_tc);
    int tc;
    clear_logs();
    fire(ctl, lnk, 32'h0000_C0F1, tc);
    wait_done();
    check("R2 no reads", rn, 0);
    check("R2 one update", wn, 1);
    check("R2 cfg kind", wkind[0], 4);
    check("R2 cfg data", wdata[0], 32'h0000_C0F0);
    check("R2 done timing", done_cyc, tc);
    check("R6 tc after disable", tc_cnt, exp_tc);
  endtask

  task automatic t_chain(input logic [31:0] lnk, input logic [31:0] ctl, input int l,
                         input logic [31:0] b, input int exp_tc);
    int tc;
    lat = l;
    clear_logs();
    fire(ctl, lnk, 32'h1, tc);
    wait_done();
    check("R3 read count", rn, 4);
    check("R3 read 0", rlog[0], b);
    check("R3 read 1", rlog[1], b + 4);
    check("R3 read 2", rlog[2], b + 12);
    check("R3 read 3", rlog[3], b + 8);
    check("R5 write count", wn, 4);
    for (int k = 0; k < 4; k++) begin
      int o;
      o = (k == 2) ? 12 : (k == 3) ? 8 : k * 4;
      check("R5 write kind", wkind[k], k);
      check("R5 write data", wdata[k], mem[(b + o) >> 2]);
    end
    check("R4 done timing", done_cyc - tc, 4 * (l + 1));
    check("R6 done count", done_cnt, 1);
    check("R6 tc new ctrl", tc_cnt, exp_tc);
    check("R7 busy span", busy_cnt, done_cyc - tc + 1);
    check("R7 busy low", {31'd0, busy}, 32'd0);
    lat = 0;
  endtask

  task automatic t_busy_ignore();
    int tc, tc2;
    lat = 1;
    clear_logs();
    fire(32'h0, 32'h40, 32'h1, tc);
    repeat (2) @(negedge clk);
    fire(32'h8000_0000, 32'h0, 32'h1, tc2);
    wait_done();
    repeat (4) @(negedge clk);
    check("R7 single done", done_cnt, 1);
    check("R7 reads unaffected", rn, 4);
    check("R7 no cfg update", wn, 4);
    check("R7 last is link", wkind[3], 3);
    lat = 0;
  endtask

  task automatic t_error();
    int tc;
    err_addr = 32'hCC;
    clear_logs();
    fire(32'h8000_0000, 32'hC0, 32'h0000_C001, tc);
    wait_done();
    repeat (4) @(negedge clk);
    check("R8 reads stop", rn, 3);
    check("R8 write count", wn, 3);
    check("R8 src kept", wkind[0], 0);
    check("R8 dst kept", wkind[1], 1);
    check("R8 cfg kind", wkind[2], 4);
    check("R8 cfg data", wdata[2], 32'h0000_C000);
    check("R8 err flag", err_cnt, 1);
    check("R8 no tc", tc_cnt, 0);
    check("R8 done timing", done_cyc - tc, 3);
    check("R8 rd_req low", {31'd0, rd_req}, 32'd0);
    err_addr = 32'hFFFF_FFFF;
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 32'h5A00_0000 + i;
    mem[16] = 32'h1000_0000; mem[17] = 32'h2000_0000;
    mem[18] = 32'h0000_0080; mem[19] = 32'h8000_0010;
    mem[32] = 32'h3333_0000; mem[33] = 32'h4444_0000;
    mem[34] = 32'h0000_0000; mem[35] = 32'h0000_0020;
    mem[48] = 32'h7777_0000; mem[49] = 32'h8888_0000;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_nonzero_count();
    t_zero_link(32'h0, 32'h8000_0000, 1);
    t_zero_link(32'h1, 32'h0000_0000, 0);
    t_chain(32'h40, 32'h0, 0, 32'h40, 1);
    t_chain(32'h83, 32'h8000_0000, 2, 32'h80, 0);
    t_busy_ignore();
    t_error();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule